// File: doc/BRIEF.md
# Multiplexed GPIO Pin Bank

This block is the control register file and pad multiplexer for a bank of 32 I/O pins. Each pin is owned either by the general-purpose I/O logic or by one of four peripheral functions. The function is picked per pin by two select bits. When the GPIO logic owns a pin, the bank's own output-data and output-enable state drive the pad. When a peripheral owns it, that peripheral's data and enable signals drive the pad. The bank also holds, for each pin, a pull-up, a pull-down and an open-drain setting, and it drives them to the pad.

Software changes every per-pin state bit through a pair of addresses. Writing ones to the first address sets the bits in the mask, and writing ones to the second clears them, so a single pin can be changed without first reading the register. A status address reads back each state vector. The two function-select vectors are plain read/write registers. A pin number in a larger system maps to bank `pin/32` and to mask bit `pin mod 32` within this bank.

Top module: `pinmux_bank`

## Requirements
- R1: After reset the GPIO logic owns every pin, output enable, output data, pull-down and open-drain are all zero, pull-up is all ones, and both select registers are zero. At the pads this gives pad_oe=0, pad_pu=all ones and pad_pd=0.
- R2: Ownership uses word address 0 to set bits (the GPIO logic takes the pin) and word address 1 to clear them (the peripheral takes the pin). Word address 2 reads the ownership vector, where 1 means GPIO.
- R3: Output enable uses set address 3, clear address 4 and status address 5. Output data uses set address 6, clear address 7 and status address 8.
- R4: A set or clear write changes only the bits that are one in the write data. A write of all zeros changes nothing.
- R5: Pull-up uses set address 9, clear address 10 and status address 11. Pull-down uses set address 12, clear address 13 and status address 14.
- R6: Open-drain uses set address 15, clear address 16 and status address 17. On an open-drain pin whose drive value is high, pad_oe is 0, so the pad is released. When the drive value is low, the pad is still driven.
- R7: Word addresses 18 (low select bit) and 19 (high select bit) are plain read/write registers. On a pin not owned by GPIO, the function index {high,low} (0=A, 1=B, 2=C, 3=D) picks periph_do and periph_oe bit `index*32+pin` to drive pad_out and pad_oe.
- R8: On a pin owned by GPIO, pad_out equals the output-data bit and pad_oe equals the output-enable bit, unless R6 releases the pad.
- R9: Word address 20 reads pad_in for all pins, whoever owns them.
- R10: pad_pd of a pin is 1 only when that pin's pull-down is enabled and its pull-up is disabled.
- R11: Read data appears on bus_rdata one clock after the read request. Set and clear addresses, and unmapped addresses, read as zero. Writes to status addresses and to address 20 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_en_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | 32 | Write data / bit mask |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the request |
| pad_in_i | input | 32 | Sampled pad levels |
| periph_do_i | input | 128 | Peripheral output data, function f at bits f*32+pin |
| periph_oe_i | input | 128 | Peripheral output enables, same layout |
| pad_out_o | output | 32 | Pad output value |
| pad_oe_o | output | 32 | Pad output enable |
| pad_pu_o | output | 32 | Pad pull-up control |
| pad_pd_o | output | 32 | Pad pull-down control |

## Verification
The hardest case to reach from the ports is a pin that is owned by a peripheral, has a non-zero function index and has its pad behaviour set by mixed peripheral inputs. Several bus writes must line up to reach it: take the pin from GPIO, set both select bits, and then rewrite one select bit. The stimulus gives each function a different drive and enable pattern on the same pin, so a wrong index shows up at pad_out or pad_oe. A second hard case sets open-drain and pull conflicts on one pin, then toggles output data and pull-up, so the release and suppression rules are seen in both directions.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int unsigned ADDR_W = 5;

    // word addresses
    localparam logic [ADDR_W-1:0] A_OWN_SET = 5'd0;
    localparam logic [ADDR_W-1:0] A_OWN_CLR = 5'd1;
    localparam logic [ADDR_W-1:0] A_OWN_STA = 5'd2;
    localparam logic [ADDR_W-1:0] A_OE_SET  = 5'd3;
    localparam logic [ADDR_W-1:0] A_OE_CLR  = 5'd4;
    localparam logic [ADDR_W-1:0] A_OE_STA  = 5'd5;
    localparam logic [ADDR_W-1:0] A_DO_SET  = 5'd6;
    localparam logic [ADDR_W-1:0] A_DO_CLR  = 5'd7;
    localparam logic [ADDR_W-1:0] A_DO_STA  = 5'd8;
    localparam logic [ADDR_W-1:0] A_PU_SET  = 5'd9;
    localparam logic [ADDR_W-1:0] A_PU_CLR  = 5'd10;
    localparam logic [ADDR_W-1:0] A_PU_STA  = 5'd11;
    localparam logic [ADDR_W-1:0] A_PD_SET  = 5'd12;
    localparam logic [ADDR_W-1:0] A_PD_CLR  = 5'd13;
    localparam logic [ADDR_W-1:0] A_PD_STA  = 5'd14;
    localparam logic [ADDR_W-1:0] A_OD_SET  = 5'd15;
    localparam logic [ADDR_W-1:0] A_OD_CLR  = 5'd16;
    localparam logic [ADDR_W-1:0] A_OD_STA  = 5'd17;
    localparam logic [ADDR_W-1:0] A_SEL_LO  = 5'd18;
    localparam logic [ADDR_W-1:0] A_SEL_HI  = 5'd19;
    localparam logic [ADDR_W-1:0] A_LEVEL   = 5'd20;

    localparam int unsigned NFUNC = 4;
    localparam int unsigned FSEL_W = $clog2(NFUNC);
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NPIN-1:0]   bus_wdata_i,
    output logic [NPIN-1:0]   bus_rdata_o,
    input  logic [NPIN-1:0]   pad_in_i,
    output logic [NPIN-1:0]   own_o,
    output logic [NPIN-1:0]   oe_o,
    output logic [NPIN-1:0]   dout_o,
    output logic [NPIN-1:0]   pu_o,
    output logic [NPIN-1:0]   pd_o,
    output logic [NPIN-1:0]   od_o,
    output logic [NPIN-1:0]   sel_lo_o,
    output logic [NPIN-1:0]   sel_hi_o
);
    typedef struct packed {
        logic [NPIN-1:0] own;
        logic [NPIN-1:0] oe;
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] pu;
        logic [NPIN-1:0] pd;
        logic [NPIN-1:0] od;
        logic [NPIN-1:0] sel_lo;
        logic [NPIN-1:0] sel_hi;
        logic [NPIN-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr, rd;

    assign wr = bus_en_i & bus_we_i;
    assign rd = bus_en_i & ~bus_we_i;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            unique case (bus_addr_i)
                A_OWN_SET: st_d.own    = st_q.own  | bus_wdata_i;
                A_OWN_CLR: st_d.own    = st_q.own  & ~bus_wdata_i;
                A_OE_SET:  st_d.oe     = st_q.oe   | bus_wdata_i;
                A_OE_CLR:  st_d.oe     = st_q.oe   & ~bus_wdata_i;
                A_DO_SET:  st_d.dout   = st_q.dout | bus_wdata_i;
                A_DO_CLR:  st_d.dout   = st_q.dout & ~bus_wdata_i;
                A_PU_SET:  st_d.pu     = st_q.pu   | bus_wdata_i;
                A_PU_CLR:  st_d.pu     = st_q.pu   & ~bus_wdata_i;
                A_PD_SET:  st_d.pd     = st_q.pd   | bus_wdata_i;
                A_PD_CLR:  st_d.pd     = st_q.pd   & ~bus_wdata_i;
                A_OD_SET:  st_d.od     = st_q.od   | bus_wdata_i;
                A_OD_CLR:  st_d.od     = st_q.od   & ~bus_wdata_i;
                A_SEL_LO:  st_d.sel_lo = bus_wdata_i;
                A_SEL_HI:  st_d.sel_hi = bus_wdata_i;
                default:   ;
            endcase
        end
        if (rd) begin
            unique case (bus_addr_i)
                A_OWN_STA: st_d.rdata = st_q.own;
                A_OE_STA:  st_d.rdata = st_q.oe;
                A_DO_STA:  st_d.rdata = st_q.dout;
                A_PU_STA:  st_d.rdata = st_q.pu;
                A_PD_STA:  st_d.rdata = st_q.pd;
                A_OD_STA:  st_d.rdata = st_q.od;
                A_SEL_LO:  st_d.rdata = st_q.sel_lo;
                A_SEL_HI:  st_d.rdata = st_q.sel_hi;
                A_LEVEL:   st_d.rdata = pad_in_i;
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.own    <= '1;
            st_q.pu     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign own_o       = st_q.own;
    assign oe_o        = st_q.oe;
    assign dout_o      = st_q.dout;
    assign pu_o        = st_q.pu;
    assign pd_o        = st_q.pd;
    assign od_o        = st_q.od;
    assign sel_lo_o    = st_q.sel_lo;
    assign sel_hi_o    = st_q.sel_hi;

    // R3
    oe_set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && bus_addr_i == A_OE_SET) |=> ((oe_o & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R2
    own_clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && bus_addr_i == A_OWN_CLR) |=> ((own_o & $past(bus_wdata_i)) == '0));

    // R4
    zero_mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && bus_wdata_i == '0 && bus_addr_i != A_SEL_LO && bus_addr_i != A_SEL_HI)
        |=> ($stable(own_o) && $stable(oe_o) && $stable(dout_o) && $stable(pu_o)
             && $stable(pd_o) && $stable(od_o)));

    // R9
    level_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd && bus_addr_i == A_LEVEL) |=> (bus_rdata_o == $past(pad_in_i)));

    // R11
    idle_rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd) |=> $stable(bus_rdata_o));
endmodule

// File: rtl/pinmux_pad.sv
module pinmux_pad
    import pinmux_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NPIN-1:0]       own_i,
    input  logic [NPIN-1:0]       oe_i,
    input  logic [NPIN-1:0]       dout_i,
    input  logic [NPIN-1:0]       pu_i,
    input  logic [NPIN-1:0]       pd_i,
    input  logic [NPIN-1:0]       od_i,
    input  logic [NPIN-1:0]       sel_lo_i,
    input  logic [NPIN-1:0]       sel_hi_i,
    input  logic [NFUNC*NPIN-1:0] periph_do_i,
    input  logic [NFUNC*NPIN-1:0] periph_oe_i,
    output logic [NPIN-1:0]       pad_out_o,
    output logic [NPIN-1:0]       pad_oe_o,
    output logic [NPIN-1:0]       pad_pu_o,
    output logic [NPIN-1:0]       pad_pd_o
);
    logic [NPIN-1:0] drv_val, drv_en;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [FSEL_W-1:0] fidx;
        logic [NFUNC-1:0]  f_do, f_oe;

        assign fidx = {sel_hi_i[p], sel_lo_i[p]};

        always_comb begin
            for (int f = 0; f < NFUNC; f++) begin
                f_do[f] = periph_do_i[f*NPIN + p];
                f_oe[f] = periph_oe_i[f*NPIN + p];
            end
        end

        assign drv_val[p]   = own_i[p] ? dout_i[p] : f_do[fidx];
        assign drv_en[p]    = own_i[p] ? oe_i[p]   : f_oe[fidx];
        assign pad_out_o[p] = drv_val[p];
        assign pad_oe_o[p]  = drv_en[p] & ~(od_i[p] & drv_val[p]);
        assign pad_pu_o[p]  = pu_i[p];
        assign pad_pd_o[p]  = pd_i[p] & ~pu_i[p];
    end

    // R6
    od_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((own_i & od_i & dout_i & pad_oe_o) == '0));

    // R8
    gpio_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((own_i & (pad_out_o ^ dout_i)) == '0));

    // R10
    pull_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pu_i & pad_pd_o) == '0));
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
    import pinmux_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_en_i,
    input  logic                  bus_we_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [NPIN-1:0]       bus_wdata_i,
    output logic [NPIN-1:0]       bus_rdata_o,
    input  logic [NPIN-1:0]       pad_in_i,
    input  logic [NFUNC*NPIN-1:0] periph_do_i,
    input  logic [NFUNC*NPIN-1:0] periph_oe_i,
    output logic [NPIN-1:0]       pad_out_o,
    output logic [NPIN-1:0]       pad_oe_o,
    output logic [NPIN-1:0]       pad_pu_o,
    output logic [NPIN-1:0]       pad_pd_o
);
    logic [NPIN-1:0] own, oe, dout, pu, pd, od, sel_lo, sel_hi;

    pinmux_regs #(.NPIN(NPIN)) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .pad_in_i    (pad_in_i),
        .own_o       (own),
        .oe_o        (oe),
        .dout_o      (dout),
        .pu_o        (pu),
        .pd_o        (pd),
        .od_o        (od),
        .sel_lo_o    (sel_lo),
        .sel_hi_o    (sel_hi)
    );

    pinmux_pad #(.NPIN(NPIN)) pad_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .own_i       (own),
        .oe_i        (oe),
        .dout_i      (dout),
        .pu_i        (pu),
        .pd_i        (pd),
        .od_i        (od),
        .sel_lo_i    (sel_lo),
        .sel_hi_i    (sel_hi),
        .periph_do_i (periph_do_i),
        .periph_oe_i (periph_oe_i),
        .pad_out_o   (pad_out_o),
        .pad_oe_o    (pad_oe_o),
        .pad_pu_o    (pad_pu_o),
        .pad_pd_o    (pad_pd_o)
    );
endmodule

// File: tb/pinmux_bank_tb.sv
module pinmux_bank_tb_top;
    import pinmux_pkg::*;

    localparam int unsigned NPIN = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       pad_in = '0;
    logic [127:0]      periph_do = '0, periph_oe = '0;
    logic [31:0]       pad_out, pad_oe, pad_pu, pad_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pinmux_bank #(.NPIN(NPIN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .pad_in_i(pad_in), .periph_do_i(periph_do), .periph_oe_i(periph_oe),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu), .pad_pd_o(pad_pd)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] data;   // write data, or expected read data
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd3,  32'h0000_00FF},  // R3 oe set
        '{1'b0, 5'd5,  32'h0000_00FF},
        '{1'b1, 5'd4,  32'h0000_000F},  // R3 oe clear
        '{1'b0, 5'd5,  32'h0000_00F0},
        '{1'b1, 5'd3,  32'h0000_0000},  // R4 zero mask
        '{1'b0, 5'd5,  32'h0000_00F0},
        '{1'b1, 5'd6,  32'hA5A5_0000},  // R3 data set
        '{1'b0, 5'd8,  32'hA5A5_0000},
        '{1'b1, 5'd7,  32'h0005_0000},  // R4 partial clear
        '{1'b0, 5'd8,  32'hA5A0_0000},
        '{1'b1, 5'd1,  32'hF000_0000},  // R2 give to peripheral
        '{1'b0, 5'd2,  32'h0FFF_FFFF},
        '{1'b1, 5'd10, 32'h0000_FFFF},  // R5 pull-up clear
        '{1'b0, 5'd11, 32'hFFFF_0000},
        '{1'b1, 5'd12, 32'h00FF_00FF},  // R5 pull-down set
        '{1'b0, 5'd14, 32'h00FF_00FF},
        '{1'b1, 5'd15, 32'h0000_0003},  // R6 open-drain set
        '{1'b0, 5'd17, 32'h0000_0003},
        '{1'b1, 5'd18, 32'h1234_5678},  // R7 plain rw
        '{1'b0, 5'd18, 32'h1234_5678},
        '{1'b1, 5'd19, 32'hCAFE_F00D},  // R7 plain rw
        '{1'b0, 5'd19, 32'hCAFE_F00D},
        '{1'b0, 5'd3,  32'h0000_0000},  // R11 set address reads zero
        '{1'b1, 5'd2,  32'hFFFF_FFFF},  // R11 status write ignored
        '{1'b0, 5'd2,  32'h0FFF_FFFF},
        '{1'b0, 5'd30, 32'h0000_0000}   // R11 unmapped reads zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        do_reset();

        // R1 reset state
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
        check("R1 pad_pd", pad_pd, 32'h0);
        rd(5'd2, r);  check("R1 own", r, 32'hFFFF_FFFF);
        rd(5'd8, r);  check("R1 dout", r, 32'h0);
        rd(5'd17, r); check("R1 od", r, 32'h0);
        rd(5'd19, r); check("R1 sel_hi", r, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, r);
                check($sformatf("R2-11 vector %0d", i), r, VECS[i].data);
            end
        end

        do_reset();

        // R8 GPIO-owned pin 0 driving high
        wr(5'd3, 32'h1);
        wr(5'd6, 32'h1);
        check("R8 pad_out", pad_out & 32'h1, 32'h1);
        check("R8 pad_oe", pad_oe & 32'h1, 32'h1);

        // R6 open-drain releases high, drives low
        wr(5'd15, 32'h1);
        check("R6 released oe", pad_oe & 32'h1, 32'h0);
        wr(5'd7, 32'h1);
        check("R6 low driven oe", pad_oe & 32'h1, 32'h1);
        check("R6 low value", pad_out & 32'h1, 32'h0);

        // R7 peripheral select on pin 4
        periph_do[3*32+4] = 1'b1; periph_oe[3*32+4] = 1'b1;  // D: high, enabled
        periph_do[2*32+4] = 1'b0; periph_oe[2*32+4] = 1'b1;  // C: low, enabled
        periph_do[1*32+4] = 1'b1; periph_oe[1*32+4] = 1'b0;  // B: high, disabled
        periph_do[0*32+4] = 1'b0; periph_oe[0*32+4] = 1'b0;  // A: off
        wr(5'd1, 32'h10);
        check("R7 function A oe", pad_oe & 32'h10, 32'h0);
        wr(5'd18, 32'h10);
        wr(5'd19, 32'h10);
        check("R7 function D out", pad_out & 32'h10, 32'h10);
        check("R7 function D oe", pad_oe & 32'h10, 32'h10);
        wr(5'd18, 32'h0);
        check("R7 function C out", pad_out & 32'h10, 32'h0);
        check("R7 function C oe", pad_oe & 32'h10, 32'h10);
        wr(5'd19, 32'h0);
        wr(5'd18, 32'h10);
        check("R7 function B oe", pad_oe & 32'h10, 32'h0);
        check("R7 function B out", pad_out & 32'h10, 32'h10);
        wr(5'd0, 32'h10);
        check("R2 back to GPIO", pad_out & 32'h10, 32'h0);

        // R10 pull conflict on pin 8
        wr(5'd12, 32'h100);
        check("R10 pd suppressed", pad_pd & 32'h100, 32'h0);
        wr(5'd10, 32'h100);
        check("R10 pd active", pad_pd & 32'h100, 32'h100);
        check("R5 pu off", pad_pu & 32'h100, 32'h0);

        // R9 level read, pin 31 owned by peripheral
        wr(5'd1, 32'h8000_0000);
        pad_in = 32'h89AB_CDEF;
        rd(5'd20, r);
        check("R9 level", r, 32'h89AB_CDEF);
        wr(5'd20, 32'h0);
        rd(5'd20, r);
        check("R11 level write ignored", r, 32'h89AB_CDEF);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule